// File: doc/BRIEF.md
# Hot-Plug Expander Link Controller

This block keeps a bank of hot-plug control outputs and a bank of hot-plug status inputs consistent with an external I/O expander on a management SMBus. Internal slot logic presents the output value it wants on `hp_out`. Whenever that value differs from the last image sent, the controller issues one SMBus write that carries the whole image, not only the bits that changed. The expander reports input changes on an active-low interrupt line. While that line is low, the controller reads every input bit and refreshes its status register.

The controller does not drive the SMBus wires. It hands byte requests to a shared bit-level master engine, one byte at a time, and the configuration-EEPROM loader uses the same engine. Each request says whether a START goes before the byte, whether the byte is sent or received, whether a received byte is NACKed, and whether a STOP follows. The engine raises a one-cycle `done` for each byte. On a sent byte it may also raise `nack`; when it does, it ends the bus transfer by itself. The controller does nothing until reset has been released and the configuration load reports complete.

The remote output register is assumed to hold all zeros after reset, so an all-zero `hp_out` needs no write. Data bytes travel least significant byte first.

Top module: `hpx_ctrl`

## Requirements
- R1: While `cfg_done` is low, `mst_req` stays low, whatever `hp_out` and `exp_int_n` do.
- R2: When `hp_out` differs from the image last sent, the controller issues exactly one write as four byte requests:
  - START + {addr, 0}
  - command 0x02
  - image bits 7:0
  - image bits 15:8 with STOP

  The write carries the value `hp_out` held when the write began.
- R3: Changes to `hp_out` that arrive while a transaction is in progress are merged into a single following write, which carries the latest value.
- R4: An input read is five byte requests:
  - START + {addr, 0}
  - command 0x00
  - repeated START + {addr, 1}
  - one received byte (status bits 7:0)
  - one received byte (status bits 15:8), NACKed and followed by STOP
- R5: `exp_int_n` passes through a two-stage synchronizer and is level-sensitive. After each read completes, another read starts while it is still low, and reads stop once it is high.
- R6: When an output write and an input read are both pending, the write goes first.
- R7: `hp_stat` changes only on the cycle after the final received byte of a successful read completes. On that cycle `stat_upd` pulses for one cycle and `stat_chg` equals the old status XOR the new status.
- R8: A NACK on a sent byte sets `nack_err`, which stays set until reset.
  - On the first NACK, the same transaction restarts once from its first byte.
  - On a second NACK, the transaction is abandoned; an abandoned write counts as sent.
- R9: Every transaction's first byte request carries START and is not a receive. A byte request and all of its fields hold steady until `mst_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Configuration load complete; enables the controller |
| cfg_addr | input | 7 | 7-bit SMBus address of the expander |
| hp_out | input | DW | Requested hot-plug output image |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| mst_req | output | 1 | Byte request valid |
| mst_start | output | 1 | Send START (or repeated START) before this byte |
| mst_stop | output | 1 | Send STOP after this byte |
| mst_read | output | 1 | Receive this byte instead of sending it |
| mst_last | output | 1 | NACK this received byte |
| mst_wdata | output | 8 | Byte to send |
| mst_done | input | 1 | One-cycle completion of the current byte |
| mst_nack | input | 1 | With `mst_done`: the sent byte was not acknowledged |
| mst_rdata | input | 8 | With `mst_done`: the received byte |
| hp_stat | output | DW | Latest hot-plug input status |
| stat_upd | output | 1 | One-cycle pulse when `hp_stat` is refreshed |
| stat_chg | output | DW | Bits that changed at the last refresh |
| nack_err | output | 1 | Sticky NACK error |

## Verification
The first byte request of a transaction appears one cycle after the idle controller sees the cause. For an output change that is the next clock. For an interrupt, two more clocks pass in the synchronizer. `hp_stat`, `stat_upd` and `stat_chg` are due on exactly the cycle after the clock edge that takes the final received byte's `mst_done`, and `nack_err` is due on the cycle after the NACKed byte's done. The bench's engine model records which of its completions are due to land, and on every falling edge it compares the outputs against that record: the pulse, the new status and the change mask must appear in that one cycle and in no other. Byte requests are checked field by field when the engine model accepts them, and again on each cycle they wait.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  typedef enum logic {KIND_WR = 1'b0, KIND_RD = 1'b1} hpx_kind_t;
  typedef enum logic {ST_IDLE = 1'b0, ST_XFER = 1'b1} hpx_state_t;

  typedef struct packed {
    logic       start;
    logic       stop;
    logic       read;
    logic       last;
    logic [7:0] data;
  } hpx_byte_t;

  localparam logic [7:0] CMD_OUT = 8'h02;
  localparam logic [7:0] CMD_IN  = 8'h00;
endpackage

// File: rtl/hpx_sync.sv
module hpx_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s0, s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= RST_VAL;
      s1 <= RST_VAL;
    end else begin
      s0 <= d;
      s1 <= s0;
    end
  end

  assign q = s1;
endmodule

// File: rtl/hpx_byte_gen.sv
module hpx_byte_gen
  import hpx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int IDX_W = 3
) (
  input  hpx_kind_t        kind,
  input  logic [IDX_W-1:0] idx,
  input  logic [6:0]       addr,
  input  logic [DW-1:0]    img,
  output hpx_byte_t        bo,
  output logic             is_last
);
  localparam int NB     = DW / 8;
  localparam int WR_LEN = 2 + NB;
  localparam int RD_LEN = 3 + NB;

  logic [IDX_W-1:0] dsel;
  assign dsel = idx - IDX_W'(2);

  always_comb begin
    bo      = '0;
    is_last = 1'b0;
    if (kind == KIND_WR) begin
      if (idx == '0) begin
        bo.start = 1'b1;
        bo.data  = {addr, 1'b0};
      end else if (idx == IDX_W'(1)) begin
        bo.data = CMD_OUT;
      end else begin
        bo.data = img[dsel*8 +: 8];
        if (idx == IDX_W'(WR_LEN - 1)) begin
          bo.stop = 1'b1;
          is_last = 1'b1;
        end
      end
    end else begin
      if (idx == '0) begin
        bo.start = 1'b1;
        bo.data  = {addr, 1'b0};
      end else if (idx == IDX_W'(1)) begin
        bo.data = CMD_IN;
      end else if (idx == IDX_W'(2)) begin
        bo.start = 1'b1;
        bo.data  = {addr, 1'b1};
      end else begin
        bo.read = 1'b1;
        if (idx == IDX_W'(RD_LEN - 1)) begin
          bo.last = 1'b1;
          bo.stop = 1'b1;
          is_last = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hpx_ctrl.sv
module hpx_ctrl
  import hpx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_done,
  input  logic [6:0]    cfg_addr,
  input  logic [DW-1:0] hp_out,
  input  logic          exp_int_n,
  output logic          mst_req,
  output logic          mst_start,
  output logic          mst_stop,
  output logic          mst_read,
  output logic          mst_last,
  output logic [7:0]    mst_wdata,
  input  logic          mst_done,
  input  logic          mst_nack,
  input  logic [7:0]    mst_rdata,
  output logic [DW-1:0] hp_stat,
  output logic          stat_upd,
  output logic [DW-1:0] stat_chg,
  output logic          nack_err
);
  localparam int NB     = DW / 8;
  localparam int RD_LEN = 3 + NB;
  localparam int IDX_W  = $clog2(RD_LEN);
  localparam int BUF_W  = DW - 8;

  logic rst_q, int_s;

  hpx_sync #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q));
  hpx_sync #(.RST_VAL(1'b1)) u_int_sync (
    .clk(clk), .rst_n(rst_q), .d(exp_int_n), .q(int_s));

  hpx_state_t       st, st_n;
  hpx_kind_t        kind, kind_n;
  logic [IDX_W-1:0] idx, idx_n, rd_sel;
  logic             retry, retry_n;
  logic [DW-1:0]    shadow, shadow_n, img, img_n;
  logic [BUF_W-1:0] rdbuf, rdbuf_n;
  logic [DW-1:0]    stat, stat_n, chg, chg_n, new_stat;
  logic             upd, upd_n, err, err_n;
  hpx_byte_t        cur;
  logic             is_last;

  hpx_byte_gen #(.DW(DW), .IDX_W(IDX_W)) u_byte_gen (
    .kind(kind), .idx(idx), .addr(cfg_addr), .img(img),
    .bo(cur), .is_last(is_last));

  assign rd_sel   = idx - IDX_W'(3);
  assign new_stat = {mst_rdata, rdbuf};

  always_comb begin
    st_n     = st;
    kind_n   = kind;
    idx_n    = idx;
    retry_n  = retry;
    shadow_n = shadow;
    img_n    = img;
    rdbuf_n  = rdbuf;
    stat_n   = stat;
    chg_n    = chg;
    upd_n    = 1'b0;
    err_n    = err;
    case (st)
      ST_IDLE: begin
        if (cfg_done) begin
          if (hp_out != shadow) begin
            st_n     = ST_XFER;
            kind_n   = KIND_WR;
            img_n    = hp_out;
            shadow_n = hp_out;
            idx_n    = '0;
            retry_n  = 1'b0;
          end else if (!int_s) begin
            st_n    = ST_XFER;
            kind_n  = KIND_RD;
            idx_n   = '0;
            retry_n = 1'b0;
          end
        end
      end
      default: begin
        if (mst_done) begin
          if (mst_nack && !cur.read) begin
            err_n = 1'b1;
            idx_n = '0;
            if (retry) st_n = ST_IDLE;
            else       retry_n = 1'b1;
          end else if (is_last) begin
            st_n = ST_IDLE;
            if (kind == KIND_RD) begin
              stat_n = new_stat;
              chg_n  = new_stat ^ stat;
              upd_n  = 1'b1;
            end
          end else begin
            idx_n = idx + IDX_W'(1);
            if (cur.read) rdbuf_n[rd_sel*8 +: 8] = mst_rdata;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st     <= ST_IDLE;
      kind   <= KIND_WR;
      idx    <= '0;
      retry  <= 1'b0;
      shadow <= '0;
      img    <= '0;
      rdbuf  <= '0;
      stat   <= '0;
      chg    <= '0;
      upd    <= 1'b0;
      err    <= 1'b0;
    end else begin
      st     <= st_n;
      kind   <= kind_n;
      idx    <= idx_n;
      retry  <= retry_n;
      shadow <= shadow_n;
      img    <= img_n;
      rdbuf  <= rdbuf_n;
      stat   <= stat_n;
      chg    <= chg_n;
      upd    <= upd_n;
      err    <= err_n;
    end
  end

  assign mst_req   = (st == ST_XFER);
  assign mst_start = mst_req & cur.start;
  assign mst_stop  = mst_req & cur.stop;
  assign mst_read  = mst_req & cur.read;
  assign mst_last  = mst_req & cur.last;
  assign mst_wdata = mst_req ? cur.data : 8'h00;
  assign hp_stat   = stat;
  assign stat_upd  = upd;
  assign stat_chg  = chg;
  assign nack_err  = err;
endmodule

// File: rtl/hpx_ctrl_chk.sv
module hpx_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_done,
  input logic          mst_req,
  input logic          mst_start,
  input logic          mst_stop,
  input logic          mst_read,
  input logic          mst_last,
  input logic [7:0]    mst_wdata,
  input logic          mst_done,
  input logic          mst_nack,
  input logic [DW-1:0] hp_stat,
  input logic          stat_upd,
  input logic [DW-1:0] stat_chg,
  input logic          nack_err
);
  assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_req) |-> $past(cfg_done));

  assert_first_byte_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_req) |-> (mst_start && !mst_read));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && !mst_done) |=> (mst_req && $stable(mst_wdata) &&
      $stable({mst_start, mst_stop, mst_read, mst_last})));

  assert_stat_only_on_upd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hp_stat) |-> stat_upd);

  assert_chg_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_upd |-> (stat_chg == (hp_stat ^ $past(hp_stat))));

  assert_upd_after_final_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_upd |-> $past(mst_req && mst_done && mst_read && mst_last));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_err |=> nack_err);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> $past(mst_done && mst_nack));
endmodule

bind hpx_ctrl hpx_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done),
  .mst_req(mst_req), .mst_start(mst_start), .mst_stop(mst_stop),
  .mst_read(mst_read), .mst_last(mst_last), .mst_wdata(mst_wdata),
  .mst_done(mst_done), .mst_nack(mst_nack), .hp_stat(hp_stat),
  .stat_upd(stat_upd), .stat_chg(stat_chg), .nack_err(nack_err));

// File: tb/hpx_ctrl_tb.sv
module hpx_ctrl_tb_top;
  localparam int DW = 16;
  localparam logic [6:0] ADDR = 7'h27;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, cfg_done, exp_int_n;
  logic [6:0]    cfg_addr;
  logic [DW-1:0] hp_out;
  logic          mst_req, mst_start, mst_stop, mst_read, mst_last;
  logic [7:0]    mst_wdata, mst_rdata;
  logic          mst_done, mst_nack;
  logic [DW-1:0] hp_stat, stat_chg;
  logic          stat_upd, nack_err;

  hpx_ctrl #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .cfg_addr(cfg_addr),
    .hp_out(hp_out), .exp_int_n(exp_int_n),
    .mst_req(mst_req), .mst_start(mst_start), .mst_stop(mst_stop),
    .mst_read(mst_read), .mst_last(mst_last), .mst_wdata(mst_wdata),
    .mst_done(mst_done), .mst_nack(mst_nack), .mst_rdata(mst_rdata),
    .hp_stat(hp_stat), .stat_upd(stat_upd), .stat_chg(stat_chg),
    .nack_err(nack_err));

  int checks = 0, fails = 0;
  bit finished = 0;
  int pos = 0, cur_kind = -1, bytes_seen = 0, wr_cnt = 0, rd_cnt = 0;
  int nack_inject = 0;
  int kinds[$];
  logic [DW-1:0] exp_in = '0, exp_reg = '0, snap = '0;
  logic [DW-1:0] model_stat = '0, upd_new = '0;
  bit model_err = 0, upd_due = 0, err_due = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle reference comparison of the status side
  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      if (upd_due) begin
        chk(stat_upd === 1'b1, "R7 upd pulse", 64'(stat_upd), 64'd1);
        chk(hp_stat === upd_new, "R7 status", 64'(hp_stat), 64'(upd_new));
        chk(stat_chg === (upd_new ^ model_stat), "R7 change mask", 64'(stat_chg), 64'(upd_new ^ model_stat));
        model_stat = upd_new;
        upd_due = 0;
      end else begin
        chk(stat_upd === 1'b0, "R7 no pulse", 64'(stat_upd), 64'd0);
        chk(hp_stat === model_stat, "R7 status hold", 64'(hp_stat), 64'(model_stat));
      end
      if (err_due) begin
        model_err = 1;
        err_due = 0;
      end
      chk(nack_err === model_err, "R8 error flag", 64'(nack_err), 64'(model_err));
    end
  endtask

  // behavioural byte engine + expander model
  initial begin : engine
    logic [11:0] f, e;
    bit fin, nk;
    mst_done = 0; mst_nack = 0; mst_rdata = '0;
    forever begin
      tick();
      mst_done = 0; mst_nack = 0;
      if (rst_n && mst_req) begin
        f = {mst_start, mst_stop, mst_read, mst_last, mst_wdata};
        fin = 0; nk = 0; bytes_seen++;
        if (pos == 0) begin
          e = {4'b1000, ADDR, 1'b0};
          snap = hp_out;
        end else if (pos == 1) begin
          cur_kind = (mst_wdata == 8'h02) ? 0 : 1;
          e = {4'b0000, (cur_kind == 0) ? 8'h02 : 8'h00};
          kinds.push_back(cur_kind);
          if (nack_inject > 0) begin nk = 1; nack_inject--; end
        end else if (cur_kind == 0) begin
          e = {1'b0, (pos == 3), 2'b00, snap[(pos-2)*8 +: 8]};
          fin = (pos == 3);
        end else if (pos == 2) begin
          e = {4'b1000, ADDR, 1'b1};
        end else if (pos == 3) begin
          e = {4'b0010, f[7:0]};
          mst_rdata = exp_in[7:0];
        end else begin
          e = {4'b0111, f[7:0]};
          mst_rdata = exp_in[15:8];
          fin = 1;
        end
        chk(f === e, (cur_kind == 1 && pos >= 2) ? "R4 read byte" : "R2 byte", 64'(f), 64'(e));
        repeat (2) begin
          tick();
          chk(mst_req === 1'b1 && {mst_start, mst_stop, mst_read, mst_last, mst_wdata} === f,
              "R9 request hold", 64'({mst_req, mst_start, mst_stop, mst_read, mst_last, mst_wdata}), 64'({1'b1, f}));
        end
        mst_done = 1; mst_nack = nk;
        if (nk) begin
          err_due = 1; pos = 0;
        end else if (fin) begin
          pos = 0;
          if (cur_kind == 0) begin exp_reg = snap; wr_cnt++; end
          else begin upd_due = 1; upd_new = exp_in; rd_cnt++; end
        end else begin
          pos++;
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int n, w0, r0;
    rst_n = 0; cfg_done = 0; exp_int_n = 1; cfg_addr = ADDR; hp_out = '0;
    step(4);
    chk(mst_req === 1'b0, "R1 reset req", 64'(mst_req), 64'd0);
    chk(hp_stat === '0, "R7 reset status", 64'(hp_stat), 64'd0);
    chk(stat_upd === 1'b0, "R7 reset pulse", 64'(stat_upd), 64'd0);
    chk(nack_err === 1'b0, "R8 reset error", 64'(nack_err), 64'd0);
    rst_n = 1;
    step(3);

    // R1 + R6: both causes pending before enable
    hp_out = 16'h00A5; exp_in = 16'h1234; exp_int_n = 0;
    step(30);
    chk(bytes_seen == 0, "R1 idle without cfg_done", 64'(bytes_seen), 64'd0);
    cfg_done = 1;
    while (rd_cnt < 1) step(1);
    exp_int_n = 1;
    step(60);
    chk(kinds.size() >= 2 && kinds[0] == 0 && kinds[1] == 1, "R6 write before read",
        64'(kinds.size() >= 2 ? {kinds[0][3:0], kinds[1][3:0]} : 8'hFF), 64'h01);
    chk(exp_reg === hp_out, "R2 image after write", 64'(exp_reg), 64'(hp_out));

    // R2: plain write, no read
    w0 = wr_cnt; r0 = rd_cnt;
    hp_out = 16'h5A3C;
    step(40);
    chk(wr_cnt == w0 + 1, "R2 one write", 64'(wr_cnt), 64'(w0 + 1));
    chk(rd_cnt == r0, "R2 no read", 64'(rd_cnt), 64'(r0));
    chk(exp_reg === 16'h5A3C, "R2 full image", 64'(exp_reg), 64'h5A3C);

    // R3: merge changes during a write
    w0 = wr_cnt;
    hp_out = 16'h1111;
    while (!(pos >= 2 && cur_kind == 0)) step(1);
    hp_out = 16'h2222;
    step(1);
    hp_out = 16'h3C33;
    step(60);
    chk(wr_cnt == w0 + 2, "R3 merged writes", 64'(wr_cnt), 64'(w0 + 2));
    chk(exp_reg === 16'h3C33, "R3 latest image", 64'(exp_reg), 64'h3C33);

    // R4/R5: level-sensitive re-read
    r0 = rd_cnt;
    exp_in = 16'hBEEF; exp_int_n = 0;
    while (rd_cnt < r0 + 3) step(1);
    chk(rd_cnt >= r0 + 3, "R5 re-read while low", 64'(rd_cnt), 64'(r0 + 3));
    exp_int_n = 1;
    step(40);
    n = rd_cnt;
    step(60);
    chk(rd_cnt == n, "R5 reads stop when high", 64'(rd_cnt), 64'(n));
    chk(hp_stat === 16'hBEEF, "R4 status bytes", 64'(hp_stat), 64'hBEEF);

    // R8: one NACK then retry succeeds
    kinds.delete(); w0 = wr_cnt;
    nack_inject = 1; hp_out = 16'h0F0F;
    step(60);
    chk(wr_cnt == w0 + 1 && exp_reg === 16'h0F0F, "R8 retry delivers", 64'(exp_reg), 64'h0F0F);
    chk(kinds.size() == 2, "R8 one retry", 64'(kinds.size()), 64'd2);

    // R8: two NACKs abandon the write
    kinds.delete(); w0 = wr_cnt;
    nack_inject = 2; hp_out = 16'hF00F;
    step(80);
    chk(kinds.size() == 2 && wr_cnt == w0, "R8 abandoned", 64'(kinds.size()), 64'd2);
    chk(exp_reg === 16'h0F0F, "R8 remote unchanged", 64'(exp_reg), 64'h0F0F);
    hp_out = 16'hF00E;
    step(40);
    chk(exp_reg === 16'hF00E, "R8 next change written", 64'(exp_reg), 64'hF00E);

    // R8 on a read: NACK then retried read
    r0 = rd_cnt; nack_inject = 1;
    exp_in = 16'h0001; exp_int_n = 0;
    while (rd_cnt < r0 + 1) step(1);
    exp_int_n = 1;
    step(60);
    chk(hp_stat === 16'h0001, "R8 read after retry", 64'(hp_stat), 64'h0001);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule